// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Error Interrupt Routing

This block receives asynchronous serial characters on one input line. It works from a strobe that the surrounding logic supplies at sixteen times the bit rate. The line first passes through a two-flop synchronizer. A falling edge is confirmed as a start bit only if the line is still low at mid-bit. Each later bit is sampled once, at its centre, sixteen strobes after the previous sample. A set of plain configuration inputs controls the receiver:

- a power bit and a receive enable, which must both be high for the receiver to run;
- a length bit that picks 7 or 8 data bits;
- a two-bit parity selector;
- a routing bit that decides which interrupt line reports a bad frame.

A received character leaves through a valid/ready stream port. The data stays on `rx_data` with `rx_valid` high until a cycle in which `rx_ready` is high. A full received word always moves on to the output, so back-pressure is never applied towards the line. If a new frame completes while the previous word is still waiting, the new word replaces it and an overrun is recorded. Three sticky status flags (framing, parity, overrun) hold until the host pulses `stat_rd`. Two one-cycle interrupt pulses report the end of a frame.

Top module: `serial_rx_core`

## Requirements
- R1: While `cfg_power` or `cfg_rx_en` is low, the receiver is held in its reset state: `rx_valid`, all three status flags and both interrupts are 0 from the next cycle, a frame in progress is abandoned, and no frame is received.
- R2: Data bits arrive LSB first. With `cfg_len8`=1 the receiver takes 8 data bits. With `cfg_len8`=0 it takes 7 data bits and `rx_data[7]` reads 0.
- R3: `cfg_parity` encoding: 00 means no parity bit; 01 means one parity bit that is consumed but never checked; 10 means odd parity (data plus parity bit hold an odd number of ones); 11 means even parity. In modes 10 and 11, a mismatch sets `stat_parity`.
- R4: In mode 01 a wrong parity bit never sets `stat_parity` and raises no error interrupt.
- R5: Only the first stop bit is checked. If it is sampled low, `stat_frame` is set.
- R6: If the line is back high at the mid-bit sample of the start bit, the low is treated as a glitch: no frame is received and the receiver returns to idle.
- R7: A frame that completes while `rx_valid` is high and `rx_ready` is low sets `stat_overrun`. It counts as an error frame, and its data replaces the waiting word.
- R8: With `cfg_err_route`=0, a frame with any error raises only `irq_err`, for one cycle.
- R9: With `cfg_err_route`=1, a frame with any error raises only `irq_done`, for one cycle.
- R10: A frame with no error raises `irq_done` for exactly one cycle and presents its data with `rx_valid`=1.
- R11: A `stat_rd` pulse clears all three status flags. A flag that is set in the same cycle stays set.
- R12: Once `rx_valid` is high, it and `rx_data` hold until a cycle with `rx_ready` high or until the receiver is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_power | input | 1 | Receiver power bit |
| cfg_rx_en | input | 1 | Receive enable; low resets the receive logic synchronously |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_parity | input | 2 | Parity mode (see R3) |
| cfg_err_route | input | 1 | 0: errors go to `irq_err`, 1: errors go to `irq_done` |
| os_tick | input | 1 | Strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_data | output | 8 | Received word |
| stat_rd | input | 1 | Status read pulse; clears the flags |
| stat_frame | output | 1 | Framing error flag |
| stat_parity | output | 1 | Parity error flag |
| stat_overrun | output | 1 | Overrun flag |
| irq_done | output | 1 | Receive-complete interrupt pulse |
| irq_err | output | 1 | Receive-error interrupt pulse |

## Verification
The bench builds the block with its default parameters: an oversample ratio of 16 and a data width of 8. This brings both character lengths within reach, with the 7-bit frame filling the upper bit with zero. The mid-bit start check lands 8 strobes after the edge, so a low pulse of a few strobes tests the glitch path directly. All four parity encodings are run in both routing settings. Overrun, status clearing and disabling (both mid-frame and through the power bit) are each tested at the stream and status ports.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_t;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_t;
endpackage

// File: rtl/srx_bit_engine.sv
module srx_bit_engine
  import srx_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          rxd,
  input  logic          len_full,
  input  logic [1:0]    par_sel,
  output logic          done,
  output logic [DW-1:0] frm_data,
  output logic          frm_ferr,
  output logic          frm_perr
);
  localparam int CW   = $clog2(OS_RATE);
  localparam int IW   = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OS_RATE/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;
  logic          par_acc, par_bit;
  logic [1:0]    sync;
  logic          rx_s;
  logic [IW-1:0] last_idx;
  logic          par_bad;
  par_mode_t     pmode;

  assign rx_s     = sync[1];
  assign pmode    = par_mode_t'(par_sel);
  assign last_idx = len_full ? IW'(DW-1) : IW'(DW-2);

  always_comb begin
    unique case (pmode)
      PAR_ODD:  par_bad = ~(par_acc ^ par_bit);
      PAR_EVEN: par_bad = par_acc ^ par_bit;
      default:  par_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; idx <= '0; sh <= '0;
      par_acc <= 1'b0; par_bit <= 1'b0; done <= 1'b0;
      frm_data <= '0; frm_ferr <= 1'b0; frm_perr <= 1'b0;
    end else if (clr) begin
      state <= S_IDLE; cnt <= '0; idx <= '0; sh <= '0;
      par_acc <= 1'b0; par_bit <= 1'b0; done <= 1'b0;
      frm_data <= '0; frm_ferr <= 1'b0; frm_perr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          S_IDLE: if (!rx_s) begin
            state <= S_START;
            cnt   <= '0;
          end
          S_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!rx_s) begin
                state <= S_DATA; idx <= '0; sh <= '0; par_acc <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              sh      <= {rx_s, sh[DW-1:1]};
              par_acc <= par_acc ^ rx_s;
              if (idx == last_idx)
                state <= (pmode == PAR_NONE) ? S_STOP : S_PAR;
              else
                idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              par_bit <= rx_s;
              state   <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt      <= '0;
              state    <= S_IDLE;
              done     <= 1'b1;
              frm_ferr <= ~rx_s;
              frm_perr <= par_bad;
              frm_data <= len_full ? sh : (sh >> 1);
            end else cnt <= cnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_result.sv
module srx_result #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          done,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_ferr,
  input  logic          frm_perr,
  input  logic          route,
  input  logic          stat_rd,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          stat_frame,
  output logic          stat_parity,
  output logic          stat_overrun,
  output logic          irq_done,
  output logic          irq_err
);
  logic ovr, any_err;

  assign ovr     = done & rx_valid & ~rx_ready;
  assign any_err = frm_ferr | frm_perr | ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; irq_done <= 1'b0; irq_err <= 1'b0;
      stat_frame <= 1'b0; stat_parity <= 1'b0; stat_overrun <= 1'b0;
    end else if (clr) begin
      rx_valid <= 1'b0; rx_data <= '0; irq_done <= 1'b0; irq_err <= 1'b0;
      stat_frame <= 1'b0; stat_parity <= 1'b0; stat_overrun <= 1'b0;
    end else begin
      irq_done <= done & (~any_err | route);
      irq_err  <= done & any_err & ~route;
      if (done) begin
        rx_valid <= 1'b1;
        rx_data  <= frm_data;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
      stat_frame   <= (stat_frame   & ~stat_rd) | (done & frm_ferr);
      stat_parity  <= (stat_parity  & ~stat_rd) | (done & frm_perr);
      stat_overrun <= (stat_overrun & ~stat_rd) | ovr;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int OS_RATE = 16,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_power,
  input  logic          cfg_rx_en,
  input  logic          cfg_len8,
  input  logic [1:0]    cfg_parity,
  input  logic          cfg_err_route,
  input  logic          os_tick,
  input  logic          rxd,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic          stat_rd,
  output logic          stat_frame,
  output logic          stat_parity,
  output logic          stat_overrun,
  output logic          irq_done,
  output logic          irq_err
);
  logic          clr;
  logic          done;
  logic [DW-1:0] frm_data;
  logic          frm_ferr, frm_perr;

  assign clr = ~(cfg_power & cfg_rx_en);

  srx_bit_engine #(.OS_RATE(OS_RATE), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(os_tick), .rxd(rxd),
    .len_full(cfg_len8), .par_sel(cfg_parity), .done(done),
    .frm_data(frm_data), .frm_ferr(frm_ferr), .frm_perr(frm_perr)
  );

  srx_result #(.DW(DW)) u_result (
    .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .frm_data(frm_data),
    .frm_ferr(frm_ferr), .frm_perr(frm_perr), .route(cfg_err_route),
    .stat_rd(stat_rd), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .stat_frame(stat_frame), .stat_parity(stat_parity),
    .stat_overrun(stat_overrun), .irq_done(irq_done), .irq_err(irq_err)
  );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_power,
  input logic          cfg_rx_en,
  input logic          cfg_len8,
  input logic [1:0]    cfg_parity,
  input logic          cfg_err_route,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          stat_frame,
  input logic          stat_parity,
  input logic          stat_overrun,
  input logic          irq_done,
  input logic          irq_err
);
  p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_power && cfg_rx_en) |=> !rx_valid && !stat_frame && !stat_parity
                                  && !stat_overrun && !irq_done && !irq_err);

  p_short_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_len8 && $stable(cfg_len8)) |-> rx_data[DW-1] == 1'b0);

  p_parity_only_checked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_parity) |-> $past(cfg_parity[1]));

  p_route_low_err_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> !irq_done && !$past(cfg_err_route));

  p_route_high_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err_route) && cfg_err_route |-> !irq_err);

  p_done_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  p_err_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |=> !irq_err);

  p_hold_until_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && cfg_power && cfg_rx_en) |=> rx_valid);
endmodule

bind serial_rx_core serial_rx_core_chk #(.DW(DW)) u_chk (.*);

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  localparam int BITCLK = 64;

  typedef struct packed {
    logic       len8;
    logic [1:0] par;
    logic       route;
    logic [7:0] data;
    logic       bad_par;
    logic       bad_stop;
    logic       exp_done;
    logic       exp_err;
    logic       exp_f;
    logic       exp_p;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b00, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 2'b00, 1'b0, 8'hD3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'b10, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'b11, 1'b0, 8'h3D, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 2'b01, 1'b0, 8'h7E, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'b00, 1'b0, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 2'b10, 1'b1, 8'hC4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'b11, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_power = 1'b1, cfg_rx_en = 1'b1, cfg_len8 = 1'b1, cfg_err_route = 1'b0;
  logic [1:0] cfg_parity = 2'b00;
  logic os_tick = 1'b0, rxd = 1'b1, rx_ready = 1'b0, stat_rd = 1'b0;
  logic rx_valid, stat_frame, stat_parity, stat_overrun, irq_done, irq_err;
  logic [7:0] rx_data;
  logic [1:0] div = '0;
  logic cnt_clr = 1'b0;
  int n_done = 0, n_err = 0, checks = 0, fails = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    div     <= div + 2'd1;
    os_tick <= (div == 2'd3);
  end

  always @(posedge clk) begin
    if (cnt_clr) begin
      n_done <= 0; n_err <= 0;
    end else begin
      if (irq_done) n_done <= n_done + 1;
      if (irq_err)  n_err  <= n_err + 1;
    end
  end

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .cfg_power(cfg_power), .cfg_rx_en(cfg_rx_en),
    .cfg_len8(cfg_len8), .cfg_parity(cfg_parity), .cfg_err_route(cfg_err_route),
    .os_tick(os_tick), .rxd(rxd), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .stat_rd(stat_rd), .stat_frame(stat_frame),
    .stat_parity(stat_parity), .stat_overrun(stat_overrun),
    .irq_done(irq_done), .irq_err(irq_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_counts();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic len8, input logic [1:0] par,
                            input logic bad_par, input logic bad_stop);
    int nb;
    logic ones;
    nb = len8 ? 8 : 7;
    ones = 1'b0;
    rxd = 1'b0; clks(BITCLK);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; ones ^= d[i]; clks(BITCLK);
    end
    if (par != 2'b00) begin
      if (par == 2'b10)      rxd = ~ones ^ bad_par;
      else if (par == 2'b11) rxd = ones ^ bad_par;
      else                   rxd = bad_par;
      clks(BITCLK);
    end
    rxd = ~bad_stop; clks(BITCLK);
    rxd = 1'b1; clks(BITCLK);
  endtask

  task automatic pulse_ready_rd();
    rx_ready = 1'b1; stat_rd = 1'b1; @(negedge clk);
    rx_ready = 1'b0; stat_rd = 1'b0; @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clks(4);
    rst_n = 1'b1;
    clks(2);
    // R1: reset state
    chk("R1 reset valid", rx_valid, 0);
    chk("R1 reset flags", {stat_frame, stat_parity, stat_overrun}, 0);
    chk("R1 reset irqs", {irq_done, irq_err}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [7:0] ed;
      t = VECS[v];
      cfg_len8 = t.len8; cfg_parity = t.par; cfg_err_route = t.route;
      ed = t.len8 ? t.data : {1'b0, t.data[6:0]};
      clr_counts();
      send_frame(t.data, t.len8, t.par, t.bad_par, t.bad_stop);
      // R2 R3 R4 R5 R8 R9 R10 per vector
      chk("R10/R9 irq_done count", n_done, int'(t.exp_done));
      chk("R8 irq_err count", n_err, int'(t.exp_err));
      chk("R10 rx_valid", rx_valid, 1);
      chk("R2 rx_data", rx_data, ed);
      chk("R5 stat_frame", stat_frame, int'(t.exp_f));
      chk("R3/R4 stat_parity", stat_parity, int'(t.exp_p));
      chk("R7 no overrun", stat_overrun, 0);
      pulse_ready_rd();
    end

    // R6: glitch shorter than half a bit
    cfg_len8 = 1'b1; cfg_parity = 2'b00; cfg_err_route = 1'b0;
    clr_counts();
    rxd = 1'b0; clks(12); rxd = 1'b1; clks(4 * BITCLK);
    chk("R6 glitch no done", n_done, 0);
    chk("R6 glitch no err", n_err, 0);
    chk("R6 glitch no valid", rx_valid, 0);
    send_frame(8'h5A, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R6 idle after glitch", rx_data, 8'h5A);

    // R12 and R7: hold, then overrun
    clr_counts();
    clks(BITCLK);
    chk("R12 held valid", rx_valid, 1);
    chk("R12 held data", rx_data, 8'h5A);
    send_frame(8'h96, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R7 overrun flag", stat_overrun, 1);
    chk("R7 overrun error irq", n_err, 1);
    chk("R7 overrun no done", n_done, 0);
    chk("R7 data replaced", rx_data, 8'h96);
    // R11: status read clears
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
    chk("R11 overrun cleared", stat_overrun, 0);
    chk("R11 data still valid", rx_valid, 1);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; @(negedge clk);
    chk("R12 accepted", rx_valid, 0);

    // R1: disable clears held word and flags
    send_frame(8'h21, 1'b1, 2'b00, 1'b0, 1'b1);
    chk("R1 pre valid", rx_valid, 1);
    chk("R1 pre frame flag", stat_frame, 1);
    cfg_rx_en = 1'b0; @(negedge clk); cfg_rx_en = 1'b1; @(negedge clk);
    chk("R1 disable valid", rx_valid, 0);
    chk("R1 disable flag", stat_frame, 0);

    // R1: disable mid-frame abandons it
    clr_counts();
    rxd = 1'b0; clks(BITCLK); rxd = 1'b1; clks(3 * BITCLK);
    cfg_rx_en = 1'b0; clks(2); cfg_rx_en = 1'b1;
    clks(10 * BITCLK);
    chk("R1 mid-frame no done", n_done + n_err, 0);
    chk("R1 mid-frame no valid", rx_valid, 0);

    // R1: power bit low blocks reception
    cfg_power = 1'b0;
    clr_counts();
    send_frame(8'h33, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R1 power off no irq", n_done + n_err, 0);
    chk("R1 power off no valid", rx_valid, 0);
    cfg_power = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule